// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block maps local addresses onto remote target addresses through a small set of programmable windows. Software reaches the window registers through an indirect scheme. It first writes a selector word that names a direction and a window number. It then writes base, limit, target and control words at fixed offsets, and those writes land in the window the selector names. The same selector steers read-back, so one set of offsets serves every window.

The lookup side takes a 64-bit local address with a valid strobe. One cycle later it returns a hit flag, the translated 64-bit address, the transaction type code, the number of the window that matched, and a 16-bit routing tag. For configuration-type windows the tag is the bus, device and function field held in the window's lower target word. Every window is compared in parallel. The lowest-numbered matching window wins.

Top module: `outbound_xlat`

## Requirements
- R1: After reset, every window field reads back as zero, the selector reads zero, and no window hits.
- R2: The selector sits at offset 0x900. Bit 31 is the direction (1 = inbound, 0 = outbound) and bit 0 is the window number. Reading it returns only those two bits, with all other bits zero.
- R3: Window fields sit at these offsets: 0x904 control word 1 (type code in bits 4:0, other bits read zero), 0x908 control word 2 (bit 31 enable, bit 30 bar-mode flag, other bits read zero), 0x90C base low, 0x910 base high, 0x914 limit, 0x918 target low, 0x91C target high. Each field is stored on its own and may be written in any order. A read returns the field of the window the selector names.
- R4: While the selector direction is inbound, writes to window offsets change nothing and reads of those offsets return zero.
- R5: A lookup hits a window when the window is enabled and {base high, base low} <= address <= {base high, limit}. Both ends are inclusive, and address bits 63:32 must fall inside this range.
- R6: On a hit, the output address is {target high, target low} + (address - {base high, base low}), taken modulo 2^64.
- R7: When several windows match, the lowest-numbered window is reported.
- R8: On a miss, the hit flag is 0, the address passes through unchanged, and the type, window number and tag are all 0.
- R9: The type output carries the matched window's type code (memory 0, I/O 2, config type 0 = 4, config type 1 = 5). For type 4 or 5, the tag equals target low bits 31:16: bus in bits 15:8, device in bits 7:3, function in bits 2:0. For any other type the tag is 0.
- R10: outValid rises exactly one cycle after each xlatValid cycle. Back-to-back lookups each produce one result, in order, using the register contents present at the sampling edge.
- R11: Offsets other than 0x900 through 0x91C read zero, and writes to them change nothing.
- R12: The bar-mode flag is stored and read back but never takes part in matching. A window with only that flag set does not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| xlatValid | input | 1 | Lookup request strobe |
| xlatAddr | input | 64 | Local address to translate |
| outValid | output | 1 | Lookup result valid |
| outHit | output | 1 | Some window matched |
| outAddr | output | 64 | Translated or passed-through address |
| outType | output | 5 | Type code of matched window |
| outRegion | output | 1 | Number of matched window |
| outBdf | output | 16 | Bus/device/function tag for configuration windows |

## Verification
The bench places two windows so that they overlap. It probes the exact base, the exact limit and limit plus one, which exposes off-by-one compares and reversed priority: a flawed unit would report window 1 inside the overlap or drop the end bytes. It enables a window before writing its base, and it writes through an inbound selector, so a design that couples fields or ignores the direction bit would read back stale or corrupted words. Lookups with nonzero upper address bits, a window carrying only the bar-mode flag, and a switch of type from configuration to I/O catch designs that match on the low word alone, that treat the bar flag as an enable, or that leak the routing tag.

// File: rtl/oatu_pkg.sv
package oatu_pkg;

  localparam int REG_ADDR_W = 12;
  localparam int DATA_W     = 32;
  localparam int XADDR_W    = 64;
  localparam int TYPE_W     = 5;
  localparam int BDF_W      = 16;
  localparam int STB_IDX_W  = 4;

  localparam logic [REG_ADDR_W-1:0] OFS_SELECT  = 12'h900;
  localparam logic [REG_ADDR_W-1:0] OFS_CTRL1   = 12'h904;
  localparam logic [REG_ADDR_W-1:0] OFS_CTRL2   = 12'h908;
  localparam logic [REG_ADDR_W-1:0] OFS_BASE_LO = 12'h90C;
  localparam logic [REG_ADDR_W-1:0] OFS_BASE_HI = 12'h910;
  localparam logic [REG_ADDR_W-1:0] OFS_LIMIT   = 12'h914;
  localparam logic [REG_ADDR_W-1:0] OFS_TGT_LO  = 12'h918;
  localparam logic [REG_ADDR_W-1:0] OFS_TGT_HI  = 12'h91C;

  localparam logic [TYPE_W-1:0] TYPE_MEM  = 5'd0;
  localparam logic [TYPE_W-1:0] TYPE_IO   = 5'd2;
  localparam logic [TYPE_W-1:0] TYPE_CFG0 = 5'd4;
  localparam logic [TYPE_W-1:0] TYPE_CFG1 = 5'd5;

  localparam int ENABLE_BIT = 31;
  localparam int BARMODE_BIT = 30;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_CTRL1,
    FLD_CTRL2,
    FLD_BASE_LO,
    FLD_BASE_HI,
    FLD_LIMIT,
    FLD_TGT_LO,
    FLD_TGT_HI
  } field_e;

  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    field_e               field;
    logic [STB_IDX_W-1:0] region;
    logic [DATA_W-1:0]    wdata;
  } strobes_t;

endpackage

// File: rtl/oatu_ctrl.sv
module oatu_ctrl
  import oatu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  input  logic [DATA_W-1:0]     fieldRdata,
  output strobes_t              stb,
  output logic [DATA_W-1:0]     regRdata
);

  localparam logic [IDX_W:0] REGION_COUNT = (IDX_W + 1)'(NUM_REGIONS);

  logic             selInbound;
  logic [IDX_W-1:0] selIndex;
  field_e           decField;
  logic             idxOk;
  logic             regionOk;
  logic             fieldHit;
  logic [DATA_W-1:0] selWord;

  // Selector register: direction and window number
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selInbound <= 1'b0;
      selIndex   <= '0;
    end else if (regWe && regAddr == OFS_SELECT) begin
      selInbound <= regWdata[DATA_W-1];
      selIndex   <= regWdata[IDX_W-1:0];
    end
  end

  // Offset decode to a window field
  always_comb begin
    unique case (regAddr)
      OFS_CTRL1:   decField = FLD_CTRL1;
      OFS_CTRL2:   decField = FLD_CTRL2;
      OFS_BASE_LO: decField = FLD_BASE_LO;
      OFS_BASE_HI: decField = FLD_BASE_HI;
      OFS_LIMIT:   decField = FLD_LIMIT;
      OFS_TGT_LO:  decField = FLD_TGT_LO;
      OFS_TGT_HI:  decField = FLD_TGT_HI;
      default:     decField = FLD_NONE;
    endcase
  end

  assign idxOk    = {1'b0, selIndex} < REGION_COUNT;
  assign regionOk = !selInbound && idxOk;
  assign fieldHit = decField != FLD_NONE;

  always_comb begin
    stb.wrEn   = regWe && regionOk && fieldHit;
    stb.rdEn   = regionOk && fieldHit;
    stb.field  = decField;
    stb.region = STB_IDX_W'(selIndex);
    stb.wdata  = regWdata;
  end

  assign selWord  = {selInbound, {(DATA_W-1-IDX_W){1'b0}}, selIndex};
  assign regRdata = (regAddr == OFS_SELECT) ? selWord : fieldRdata;

  AST_INBOUND_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && selInbound) |-> !stb.wrEn); // R4

  AST_WRITE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> (regWe && regAddr != OFS_SELECT)); // R3

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr < OFS_SELECT || regAddr > OFS_TGT_HI) |-> regRdata == '0); // R11

endmodule

// File: rtl/oatu_datapath.sv
module oatu_datapath
  import oatu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  output logic [DATA_W-1:0]  fieldRdata,
  input  logic               xlatValid,
  input  logic [XADDR_W-1:0] xlatAddr,
  output logic               outValid,
  output logic               outHit,
  output logic [XADDR_W-1:0] outAddr,
  output logic [TYPE_W-1:0]  outType,
  output logic [IDX_W-1:0]   outRegion,
  output logic [BDF_W-1:0]   outBdf
);

  logic [DATA_W-1:0] baseLo  [NUM_REGIONS];
  logic [DATA_W-1:0] baseHi  [NUM_REGIONS];
  logic [DATA_W-1:0] limitLo [NUM_REGIONS];
  logic [DATA_W-1:0] tgtLo   [NUM_REGIONS];
  logic [DATA_W-1:0] tgtHi   [NUM_REGIONS];
  logic [TYPE_W-1:0] rType   [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] rEnable;
  logic [NUM_REGIONS-1:0] rBarMode;

  logic [NUM_REGIONS-1:0] hitVec;
  logic [XADDR_W-1:0]     mapAddr [NUM_REGIONS];
  logic [BDF_W-1:0]       mapBdf  [NUM_REGIONS];

  logic               anyHit;
  logic [IDX_W-1:0]   selIdx;
  logic [XADDR_W-1:0] selAddr;
  logic [TYPE_W-1:0]  selType;
  logic [BDF_W-1:0]   selBdf;

  // Field storage: each word written on its own strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        baseLo[i]  <= '0;
        baseHi[i]  <= '0;
        limitLo[i] <= '0;
        tgtLo[i]   <= '0;
        tgtHi[i]   <= '0;
        rType[i]   <= '0;
      end
      rEnable  <= '0;
      rBarMode <= '0;
    end else if (stb.wrEn) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (stb.region == STB_IDX_W'(i)) begin
          unique case (stb.field)
            FLD_CTRL1:   rType[i]   <= stb.wdata[TYPE_W-1:0];
            FLD_CTRL2: begin
              rEnable[i]  <= stb.wdata[ENABLE_BIT];
              rBarMode[i] <= stb.wdata[BARMODE_BIT];
            end
            FLD_BASE_LO: baseLo[i]  <= stb.wdata;
            FLD_BASE_HI: baseHi[i]  <= stb.wdata;
            FLD_LIMIT:   limitLo[i] <= stb.wdata;
            FLD_TGT_LO:  tgtLo[i]   <= stb.wdata;
            FLD_TGT_HI:  tgtHi[i]   <= stb.wdata;
            default: ;
          endcase
        end
      end
    end
  end

  // Read-back of the selected window
  always_comb begin
    fieldRdata = '0;
    if (stb.rdEn) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (stb.region == STB_IDX_W'(i)) begin
          unique case (stb.field)
            FLD_CTRL1:   fieldRdata = DATA_W'(rType[i]);
            FLD_CTRL2:   fieldRdata = {rEnable[i], rBarMode[i], {(DATA_W-2){1'b0}}};
            FLD_BASE_LO: fieldRdata = baseLo[i];
            FLD_BASE_HI: fieldRdata = baseHi[i];
            FLD_LIMIT:   fieldRdata = limitLo[i];
            FLD_TGT_LO:  fieldRdata = tgtLo[i];
            FLD_TGT_HI:  fieldRdata = tgtHi[i];
            default:     fieldRdata = '0;
          endcase
        end
      end
    end
  end

  // Parallel window compare and offset translation
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gWindow
    logic [XADDR_W-1:0] winBase;
    logic [XADDR_W-1:0] winLast;
    logic [XADDR_W-1:0] winTarget;
    logic               isCfg;

    assign winBase   = {baseHi[g], baseLo[g]};
    assign winLast   = {baseHi[g], limitLo[g]};
    assign winTarget = {tgtHi[g], tgtLo[g]};
    assign isCfg     = (rType[g] == TYPE_CFG0) || (rType[g] == TYPE_CFG1);

    assign hitVec[g]  = rEnable[g] && (xlatAddr >= winBase) && (xlatAddr <= winLast);
    assign mapAddr[g] = winTarget + (xlatAddr - winBase);
    assign mapBdf[g]  = isCfg ? tgtLo[g][DATA_W-1:DATA_W-BDF_W] : '0;
  end

  // Lowest-numbered matching window wins
  always_comb begin
    anyHit  = 1'b0;
    selIdx  = '0;
    selAddr = xlatAddr;
    selType = TYPE_MEM;
    selBdf  = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit  = 1'b1;
        selIdx  = IDX_W'(i);
        selAddr = mapAddr[i];
        selType = rType[i];
        selBdf  = mapBdf[i];
      end
    end
  end

  // One result stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outHit    <= 1'b0;
      outAddr   <= '0;
      outType   <= '0;
      outRegion <= '0;
      outBdf    <= '0;
    end else begin
      outValid <= xlatValid;
      if (xlatValid) begin
        outHit    <= anyHit;
        outAddr   <= selAddr;
        outType   <= selType;
        outRegion <= selIdx;
        outBdf    <= selBdf;
      end
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    xlatValid |=> outValid); // R10

  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outHit) |-> (outAddr == $past(xlatAddr) && outType == '0
                               && outRegion == '0 && outBdf == '0)); // R8

  AST_TAG_ONLY_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outType != TYPE_CFG0 && outType != TYPE_CFG1) |-> outBdf == '0); // R9

  AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (xlatValid && rEnable == '0) |=> !outHit); // R12

endmodule

// File: rtl/outbound_xlat.sv
module outbound_xlat
  import oatu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [11:0] regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        xlatValid,
  input  logic [63:0] xlatAddr,
  output logic        outValid,
  output logic        outHit,
  output logic [63:0] outAddr,
  output logic [4:0]  outType,
  output logic [IDX_W-1:0] outRegion,
  output logic [15:0] outBdf
);

  strobes_t          stb;
  logic [DATA_W-1:0] fieldRdata;

  oatu_ctrl #(.NUM_REGIONS(NUM_REGIONS)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .fieldRdata (fieldRdata),
    .stb        (stb),
    .regRdata   (regRdata)
  );

  oatu_datapath #(.NUM_REGIONS(NUM_REGIONS)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .fieldRdata (fieldRdata),
    .xlatValid  (xlatValid),
    .xlatAddr   (xlatAddr),
    .outValid   (outValid),
    .outHit     (outHit),
    .outAddr    (outAddr),
    .outType    (outType),
    .outRegion  (outRegion),
    .outBdf     (outBdf)
  );

endmodule

// File: tb/outbound_xlat_test.sv
`timescale 1ns/1ps
module outbound_xlat_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        xlatValid = 1'b0;
  logic [63:0] xlatAddr = '0;
  logic        outValid;
  logic        outHit;
  logic [63:0] outAddr;
  logic [4:0]  outType;
  logic [0:0]  outRegion;
  logic [15:0] outBdf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  outbound_xlat uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .xlatValid(xlatValid), .xlatAddr(xlatAddr), .outValid(outValid),
    .outHit(outHit), .outAddr(outAddr), .outType(outType), .outRegion(outRegion), .outBdf(outBdf)
  );

  // Bench model of window fields, built from the requirements
  logic [31:0] mBaseLo[2], mBaseHi[2], mLimit[2], mTgtLo[2], mTgtHi[2];
  logic [4:0]  mType[2];
  bit          mEn[2], mBar[2];
  bit          mInbound = 0;
  int          mIdx = 0;

  typedef struct packed {
    logic        hit;
    logic [63:0] addr;
    logic [4:0]  typ;
    logic        region;
    logic [15:0] bdf;
  } expect_t;

  expect_t expQ[$];
  string   tagQ[$];
  int      outSeen = 0;

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
    if (a == 12'h900) begin
      mInbound = d[31]; mIdx = int'(d[0]);
    end else if (!mInbound) begin
      case (a)
        12'h904: mType[mIdx] = d[4:0];
        12'h908: begin mEn[mIdx] = d[31]; mBar[mIdx] = d[30]; end
        12'h90C: mBaseLo[mIdx] = d;
        12'h910: mBaseHi[mIdx] = d;
        12'h914: mLimit[mIdx] = d;
        12'h918: mTgtLo[mIdx] = d;
        12'h91C: mTgtHi[mIdx] = d;
        default: ;
      endcase
    end
  endtask

  task automatic regCheck(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(posedge clk); #1;
    regAddr = a;
    #1;
    check32(tag, regRdata, exp);
  endtask

  function automatic expect_t predict(input logic [63:0] a);
    expect_t e;
    e.hit = 0; e.addr = a; e.typ = 0; e.region = 0; e.bdf = 0;
    for (int i = 1; i >= 0; i--) begin
      if (mEn[i] && a >= {mBaseHi[i], mBaseLo[i]} && a <= {mBaseHi[i], mLimit[i]}) begin
        e.hit = 1;
        e.addr = {mTgtHi[i], mTgtLo[i]} + (a - {mBaseHi[i], mBaseLo[i]});
        e.typ = mType[i];
        e.region = 1'(i);
        e.bdf = (mType[i] == 5'd4 || mType[i] == 5'd5) ? mTgtLo[i][31:16] : 16'h0;
      end
    end
    return e;
  endfunction

  // Driver: leaves xlatValid high; call xlatStop afterwards
  task automatic xlat(input string tag, input logic [63:0] a);
    @(posedge clk); #1;
    xlatValid = 1'b1; xlatAddr = a;
    expQ.push_back(predict(a));
    tagQ.push_back(tag);
  endtask

  task automatic xlatStop();
    @(posedge clk); #1;
    xlatValid = 1'b0;
    @(posedge clk); #1;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      expect_t e;
      string t;
      outSeen++;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected result, actual hit=%0b addr=0x%016h expected none", outHit, outAddr);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (outHit !== e.hit || outAddr !== e.addr || outType !== e.typ ||
            outRegion !== e.region || outBdf !== e.bdf) begin
          errors++;
          $display("FAIL %s: actual hit=%0b addr=0x%016h type=%0d reg=%0d bdf=0x%04h expected hit=%0b addr=0x%016h type=%0d reg=%0d bdf=0x%04h",
                   t, outHit, outAddr, outType, outRegion, outBdf, e.hit, e.addr, e.typ, e.region, e.bdf);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      mBaseLo[i] = 0; mBaseHi[i] = 0; mLimit[i] = 0; mTgtLo[i] = 0; mTgtHi[i] = 0;
      mType[i] = 0; mEn[i] = 0; mBar[i] = 0;
    end
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    regCheck("R1 select", 12'h900, 32'h0);
    for (int o = 12'h904; o <= 12'h91C; o += 4) regCheck("R1 field", 12'(o), 32'h0);
    xlat("R1 no hit", 64'h0);
    xlatStop();

    // R2: selector bits
    regWrite(12'h900, 32'hFFFF_FFFF);
    regCheck("R2 select mask", 12'h900, 32'h8000_0001);
    regWrite(12'h900, 32'h0000_0000);
    regCheck("R2 select clear", 12'h900, 32'h0);

    // R3: window 0 enabled before its base, memory type
    regWrite(12'h908, 32'hFFFF_FFFF);
    regCheck("R3 ctrl2 mask", 12'h908, 32'hC000_0000);
    regWrite(12'h908, 32'h8000_0000);
    regWrite(12'h904, 32'hFFFF_FFE0);
    regCheck("R3 ctrl1 mask", 12'h904, 32'h0);
    regWrite(12'h90C, 32'h4000_0000);
    regWrite(12'h910, 32'h0);
    regWrite(12'h914, 32'h4000_FFFF);
    regWrite(12'h918, 32'h3400_0000);
    regWrite(12'h91C, 32'h0000_0012);
    regCheck("R3 base lo", 12'h90C, 32'h4000_0000);
    regCheck("R3 limit", 12'h914, 32'h4000_FFFF);
    regCheck("R3 tgt lo", 12'h918, 32'h3400_0000);
    regCheck("R3 tgt hi", 12'h91C, 32'h0000_0012);

    // R3: window 1, configuration type 0, overlapping window 0
    regWrite(12'h900, 32'h1);
    regWrite(12'h904, 32'h4);
    regWrite(12'h91C, 32'h0);
    regWrite(12'h918, 32'h032A_0000);
    regWrite(12'h914, 32'h4001_7FFF);
    regWrite(12'h90C, 32'h4000_8000);
    regWrite(12'h908, 32'h8000_0000);
    regCheck("R3 w1 ctrl1", 12'h904, 32'h4);
    regCheck("R3 w1 base", 12'h90C, 32'h4000_8000);
    regWrite(12'h900, 32'h0);
    regCheck("R3 w0 untouched", 12'h90C, 32'h4000_0000);

    // R4: inbound selector
    regWrite(12'h900, 32'h8000_0000);
    regCheck("R4 inbound read zero", 12'h90C, 32'h0);
    regWrite(12'h90C, 32'hDEAD_0000);
    regWrite(12'h908, 32'h0);
    regWrite(12'h900, 32'h0);
    regCheck("R4 base kept", 12'h90C, 32'h4000_0000);
    regCheck("R4 enable kept", 12'h908, 32'h8000_0000);

    // R11: unmapped offsets
    regWrite(12'h920, 32'hFFFF_FFFF);
    regCheck("R11 unmapped read", 12'h920, 32'h0);
    regCheck("R11 neighbour kept", 12'h91C, 32'h0000_0012);
    regCheck("R11 low offset", 12'h000, 32'h0);

    // R5..R10 lookups, back to back
    xlat("R5 exact base", 64'h0000_0000_4000_0000);
    xlat("R6 offset add", 64'h0000_0000_4000_1234);
    xlat("R7 overlap to window 0", 64'h0000_0000_4000_8000);
    xlat("R5 exact limit", 64'h0000_0000_4000_FFFF);
    xlat("R7 past window 0 limit", 64'h0000_0000_4001_0000);
    xlat("R9 cfg tag", 64'h0000_0000_4001_2345);
    xlat("R5 window 1 limit", 64'h0000_0000_4001_7FFF);
    xlat("R8 above all", 64'h0000_0000_4001_8000);
    xlat("R8 below all", 64'h0000_0000_3FFF_FFFF);
    xlat("R5 upper bits", 64'h0000_0001_4000_0000);
    xlatStop();

    // R12: window 1 with bar flag only
    regWrite(12'h900, 32'h1);
    regWrite(12'h908, 32'h4000_0000);
    regCheck("R12 bar readback", 12'h908, 32'h4000_0000);
    xlat("R12 bar no hit", 64'h0000_0000_4001_2345);
    xlatStop();
    regWrite(12'h908, 32'hC000_0000);
    xlat("R12 bar with enable", 64'h0000_0000_4001_2345);
    xlatStop();

    // R9: type change to I/O drops tag; config type 1 keeps it
    regWrite(12'h904, 32'h2);
    xlat("R9 io no tag", 64'h0000_0000_4001_0010);
    xlatStop();
    regWrite(12'h904, 32'h5);
    xlat("R9 cfg1 tag", 64'h0000_0000_4001_0010);
    xlatStop();

    // R6: wraparound within 64 bits, window 0 target near top
    regWrite(12'h900, 32'h0);
    regWrite(12'h91C, 32'hFFFF_FFFF);
    regWrite(12'h918, 32'hFFFF_FFF0);
    xlat("R6 wrap", 64'h0000_0000_4000_0020);
    xlatStop();

    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (expQ.size() != 0 || outSeen != 16) begin
      errors++;
      $display("FAIL R10: actual %0d results, %0d pending expected 16 results, 0 pending", outSeen, expQ.size());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule